// File: doc/BRIEF.md
# Byte-lane SRAM access port with store hold-off

This block is a clocked model of a 16-bit static RAM sitting behind active-low control pins: a chip select, an output enable, a write strobe and one select per byte lane. Every clock edge it classifies the pins into one access kind: idle, read, write or inhibited. A read returns the selected lanes of the addressed word one clock later, and marks which lanes are being driven. A write updates only the selected lanes and raises a one-cycle pulse that a store controller can use to note that the array holds unsaved data.

Two inputs stop all access. One flags a nonvolatile transfer (store or recall) in progress. The other is the active-low hardware-store request line. While either is asserted, no read drives the bus and no write reaches the array. When both clear, normal decoding resumes on the next edge. Analog access times are replaced by one registered cycle.

The controller is a four-state machine that is re-entered every clock from a combinational decode of the pins:

- **IDLE**: the chip is deselected, or no byte lane is selected, or neither the read nor the write strobe is active.
- **READ**: select low, output enable low, write strobe high, at least one lane selected.
- **WRITE**: select low, write strobe low, at least one lane selected.
- **INHIBIT**: the transfer flag is high or the hardware-store line is low. This test has the highest priority.

Any state can move to any other on the next edge. INHIBIT takes precedence over WRITE, and WRITE takes precedence over READ.

Top module: `sram_gate_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `rdata`, `data_oe` and `write_done` are all zero.
- R2: A read occurs when `ce_n`=0, `oe_n`=0, `we_n`=1, `hsb_n`=1, `xfer_busy`=0 and at least one lane is selected. On the following cycle `rdata` carries the stored word. `data_oe[0]` is set when `ble_n`=0 and covers bits 7:0; `data_oe[1]` is set when `bhe_n`=0 and covers bits 15:8.
- R3: A write occurs when `ce_n`=0, `we_n`=0, `hsb_n`=1, `xfer_busy`=0 and at least one lane is selected. The write changes only the selected lanes of `addr`; an unselected lane keeps its earlier value.
- R4: During a read, a lane whose select is high reads as zero in `rdata` and has its `data_oe` bit clear.
- R5: A write with `oe_n` low drives nothing: on the next cycle `data_oe` is 0 and `rdata` is 0.
- R6: While `xfer_busy`=1, reads produce no output (`data_oe`=0, `rdata`=0) and writes leave the array unchanged.
- R7: While `hsb_n`=0, writes are refused and reads produce no output. Access resumes on the first edge at which `hsb_n` is high again.
- R8: While the read conditions stay true, each new `addr` value returns that word on the next cycle, with no control pin toggled.
- R9: `write_done` is high for exactly the cycle after each edge that accepts a write, and is low in every other cycle.
- R10: With `ce_n`=1, or with both `ble_n` and `bhe_n` high, the port is idle: the array is unchanged, `data_oe`=0 and `write_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| ble_n | input | 1 | Low byte lane select (bits 7:0), active low |
| bhe_n | input | 1 | High byte lane select (bits 15:8), active low |
| hsb_n | input | 1 | Hardware-store request line, active low; low blocks access |
| xfer_busy | input | 1 | Nonvolatile store/recall in progress; high blocks access |
| addr | input | ADDR_W | Word address |
| wdata | input | 2*LANE_W | Write data |
| rdata | output | 2*LANE_W | Registered read data; a lane not driven reads as zero |
| data_oe | output | 2 | Per-lane bus drive enable (bit 0 low lane, bit 1 high lane) |
| write_done | output | 1 | One-cycle pulse per accepted write |

## Verification
The main function is exercised with full-word writes, single-lane writes and reads of each lane alone. Together these show whether lane masking is applied correctly and whether each lane is tied to the right select. A run of reads at changing addresses with no control toggling separates a port that re-decodes every cycle from one that latches only the first access. Writes and reads issued under the transfer flag, under a low hardware-store line, with the chip deselected and with no lane selected are each followed by a clean read-back. That read-back shows whether the blocked request was truly dropped or only hidden on the outputs. A write with output enable low and back-to-back writes tell apart correct bus release and a correct per-write pulse from a merged or missing pulse.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;

    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_INHIBIT
    } acc_state_e;

endpackage

// File: rtl/sram_gate_decode.sv
module sram_gate_decode
    import sram_gate_pkg::*;
(
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 hsb_n,
    input  logic                 xfer_busy,
    input  logic [NUM_LANES-1:0] lane_sel,
    output acc_state_e           next_state
);

    always_comb begin
        if (xfer_busy || !hsb_n) begin
            next_state = ST_INHIBIT;
        end else if (ce_n || (lane_sel == '0)) begin
            next_state = ST_IDLE;
        end else if (!we_n) begin
            next_state = ST_WRITE;
        end else if (!oe_n) begin
            next_state = ST_READ;
        end else begin
            next_state = ST_IDLE;
        end
    end

endmodule

// File: rtl/sram_gate_lane.sv
module sram_gate_lane #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_en ? mem[addr] : '0;
        end
    end

endmodule

// File: rtl/sram_gate_port.sv
module sram_gate_port
    import sram_gate_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce_n,
    input  logic                          oe_n,
    input  logic                          we_n,
    input  logic                          ble_n,
    input  logic                          bhe_n,
    input  logic                          hsb_n,
    input  logic                          xfer_busy,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_LANES*LANE_W-1:0]   wdata,
    output logic [NUM_LANES*LANE_W-1:0]   rdata,
    output logic [NUM_LANES-1:0]          data_oe,
    output logic                          write_done
);

    localparam int DATA_W = NUM_LANES * LANE_W;

    logic [NUM_LANES-1:0] lane_sel;
    logic [NUM_LANES-1:0] lanes_q;
    logic [DATA_W-1:0]    rd_word;
    acc_state_e           next_state;
    acc_state_e           state_q;

    assign lane_sel = {~bhe_n, ~ble_n};

    sram_gate_decode u_decode (
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .hsb_n      (hsb_n),
        .xfer_busy  (xfer_busy),
        .lane_sel   (lane_sel),
        .next_state (next_state)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sram_gate_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en ((next_state == ST_WRITE) && lane_sel[g]),
            .rd_en ((next_state == ST_READ) && lane_sel[g]),
            .addr  (addr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lanes_q <= '0;
        end else begin
            state_q <= next_state;
            lanes_q <= (next_state == ST_READ) ? lane_sel : '0;
        end
    end

    // Outputs
    always_comb begin
        rdata      = '0;
        data_oe    = '0;
        write_done = 1'b0;
        unique case (state_q)
            ST_READ: begin
                rdata   = rd_word;
                data_oe = lanes_q;
            end
            ST_WRITE:   write_done = 1'b1;
            ST_IDLE:    ;
            ST_INHIBIT: ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/sram_gate_port_chk.sv
module sram_gate_port_chk #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ce_n,
    input logic                oe_n,
    input logic                we_n,
    input logic                ble_n,
    input logic                bhe_n,
    input logic                hsb_n,
    input logic                xfer_busy,
    input logic [ADDR_W-1:0]   addr,
    input logic [2*LANE_W-1:0] rdata,
    input logic [1:0]          data_oe,
    input logic                write_done
);

    p_wd_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        write_done |-> $past(rst_n && !ce_n && !we_n && hsb_n && !xfer_busy && !(ble_n && bhe_n)));

    p_no_drive_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_n && !we_n && hsb_n && !xfer_busy) |-> (data_oe == 2'b00));

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_busy) |-> (data_oe == 2'b00 && !write_done && rdata == '0));

    p_hsb_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hsb_n) |-> (data_oe == 2'b00 && !write_done));

    p_lane_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe[0] |-> (rdata[LANE_W-1:0] == '0));

    p_lane_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe[1] |-> (rdata[2*LANE_W-1:LANE_W] == '0));

    p_read_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_n && !oe_n && we_n && hsb_n && !xfer_busy)
            |-> (data_oe == $past({~bhe_n, ~ble_n})));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n || (ble_n && bhe_n)) |-> (data_oe == 2'b00 && !write_done));

endmodule

bind sram_gate_port sram_gate_port_chk #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .ble_n      (ble_n),
    .bhe_n      (bhe_n),
    .hsb_n      (hsb_n),
    .xfer_busy  (xfer_busy),
    .addr       (addr),
    .rdata      (rdata),
    .data_oe    (data_oe),
    .write_done (write_done)
);

// File: tb/sram_gate_port_tb_top.sv
module sram_gate_port_tb_top;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, oe_n, we_n, ble_n, bhe_n, hsb_n, xfer_busy;
    logic [AW-1:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  data_oe;
    logic        write_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_lo [int];
    logic [7:0] m_hi [int];

    always #5 clk = ~clk;

    sram_gate_port #(.ADDR_W(AW), .LANE_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .ble_n      (ble_n),
        .bhe_n      (bhe_n),
        .hsb_n      (hsb_n),
        .xfer_busy  (xfer_busy),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .data_oe    (data_oe),
        .write_done (write_done)
    );

    task automatic compare(input string tag, input logic [15:0] e_rd,
                           input logic [1:0] e_oe, input logic e_wd);
        n_checks++;
        if (rdata !== e_rd || data_oe !== e_oe || write_done !== e_wd) begin
            n_fail++;
            $display("FAIL %s: rdata=%h oe=%b wd=%b expected rdata=%h oe=%b wd=%b",
                     tag, rdata, data_oe, write_done, e_rd, e_oe, e_wd);
        end
    endtask

    // Drive one cycle of pins, predict the outcome, check after the edge.
    task automatic step(input string tag, input logic c, input logic o, input logic w,
                        input logic bl, input logic bh, input logic h, input logic b,
                        input logic [AW-1:0] a, input logic [15:0] d);
        logic [15:0] e_rd;
        logic [1:0]  e_oe;
        logic        e_wd;
        logic [1:0]  sel;
        ce_n = c; oe_n = o; we_n = w; ble_n = bl; bhe_n = bh;
        hsb_n = h; xfer_busy = b; addr = a; wdata = d;
        sel  = {~bh, ~bl};
        e_rd = '0; e_oe = '0; e_wd = 1'b0;
        if (!b && h && !c && sel != 2'b00) begin
            if (!w) begin
                e_wd = 1'b1;
                if (sel[0]) m_lo[int'(a)] = d[7:0];
                if (sel[1]) m_hi[int'(a)] = d[15:8];
            end else if (!o) begin
                e_oe = sel;
                if (sel[0]) e_rd[7:0]  = m_lo[int'(a)];
                if (sel[1]) e_rd[15:8] = m_hi[int'(a)];
            end
        end
        @(posedge clk);
        #1;
        compare(tag, e_rd, e_oe, e_wd);
    endtask

    initial begin
        rst_n = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; ble_n = 1'b1; bhe_n = 1'b1;
        hsb_n = 1'b1; xfer_busy = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 in reset", 16'h0, 2'b00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare("R1 after reset", 16'h0, 2'b00, 1'b0);

        //            tag               ce oe we bl bh hsb busy addr   data
        step("R3 R9 full write",         0, 1, 0, 0, 0, 1, 0, 8'd5,  16'hA55A);
        step("R3 R9 full write",         0, 1, 0, 0, 0, 1, 0, 8'd6,  16'hFFFF);
        step("R3 low lane write",        0, 1, 0, 0, 1, 1, 0, 8'd6,  16'h0012);
        step("R3 high lane write",       0, 1, 0, 1, 0, 1, 0, 8'd7,  16'h3400);
        step("R3 low lane write",        0, 1, 0, 0, 1, 1, 0, 8'd7,  16'h0056);
        step("R9 gap",                   1, 1, 1, 1, 1, 1, 0, 8'd0,  16'h0);
        step("R2 full read",             0, 0, 1, 0, 0, 1, 0, 8'd5,  16'h0);
        step("R3 merged read",           0, 0, 1, 0, 0, 1, 0, 8'd6,  16'h0);
        step("R4 high lane only read",   0, 0, 1, 1, 0, 1, 0, 8'd6,  16'h0);
        step("R4 low lane only read",    0, 0, 1, 0, 1, 1, 0, 8'd7,  16'h0);
        step("R8 follow addr",           0, 0, 1, 0, 0, 1, 0, 8'd7,  16'h0);
        step("R8 follow addr",           0, 0, 1, 0, 0, 1, 0, 8'd5,  16'h0);
        step("R8 follow addr",           0, 0, 1, 0, 0, 1, 0, 8'd6,  16'h0);
        step("R5 write with oe low",     0, 0, 0, 0, 0, 1, 0, 8'd8,  16'hBEEF);
        step("R2 read back",             0, 0, 1, 0, 0, 1, 0, 8'd8,  16'h0);
        step("R6 busy write",            0, 1, 0, 0, 0, 1, 1, 8'd5,  16'h0000);
        step("R6 busy read",             0, 0, 1, 0, 0, 1, 1, 8'd5,  16'h0);
        step("R6 read back",             0, 0, 1, 0, 0, 1, 0, 8'd5,  16'h0);
        step("R7 hsb write",             0, 1, 0, 0, 0, 0, 0, 8'd6,  16'h1111);
        step("R7 hsb read",              0, 0, 1, 0, 0, 0, 0, 8'd6,  16'h0);
        step("R7 resume read",           0, 0, 1, 0, 0, 1, 0, 8'd6,  16'h0);
        step("R10 deselected write",     1, 1, 0, 0, 0, 1, 0, 8'd7,  16'h2222);
        step("R10 no lane write",        0, 1, 0, 1, 1, 1, 0, 8'd7,  16'h3333);
        step("R10 no lane read",         0, 0, 1, 1, 1, 1, 0, 8'd7,  16'h0);
        step("R10 read back",            0, 0, 1, 0, 0, 1, 0, 8'd7,  16'h0);
        step("R9 back to back",          0, 1, 0, 0, 0, 1, 0, 8'd9,  16'h0102);
        step("R9 back to back",          0, 1, 0, 0, 0, 1, 0, 8'd10, 16'h0304);
        step("R9 idle after",            0, 1, 1, 0, 0, 1, 0, 8'd10, 16'h0);
        step("R2 read back",             0, 0, 1, 0, 0, 1, 0, 8'd9,  16'h0);
        step("R2 read back",             0, 0, 1, 0, 0, 1, 0, 8'd10, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule